// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Single-Bit LRU

This block sits between a 32-bit processor load/store port and a slower next-level memory. It keeps a small number of one-word lines in a two-way set-associative array. Each set has one use bit, and that bit names the way to replace on the next miss in the set. A processor request that finds its word in the array is answered without any memory traffic. A read that misses sends one word request to the next level, stalls until that level answers, writes the returned word into the chosen way, and passes the word back to the processor.

Stores always go straight through to the next level. A store whose address is already cached also updates the cached copy, so later reads stay consistent with memory. A store that misses does not bring the word into the cache.

The processor side uses a one-cycle request strobe. A request can only be presented while `cpu_busy` is low. Completion is shown by a one-cycle `cpu_done` pulse, which comes with a hit flag and, for reads, the data. The memory side holds a request level high until a one-cycle ready pulse arrives.

Top module: `lru2_cache`

## Requirements
- R1: After reset every way is invalid and every use bit is 0. `cpu_busy`, `cpu_done`, `cpu_hit` and `mem_req` are low, and `cpu_rdata` is 0.
- R2: The set index is address bits [3:2] and the tag is bits [31:4]. Bits [1:0] take no part in the lookup, so byte addresses that differ only in those bits find the same word.
- R3: A read hit raises `cpu_done` for exactly one cycle, two clock edges after the request is accepted. The pulse comes with `cpu_hit`=1 and the cached word, and no memory request is made.
- R4: A read miss raises `mem_req` with `mem_we`=0 and `mem_addr` = request address bits [31:2]. After `mem_ready`, `cpu_done` pulses with `cpu_hit`=0 and `cpu_rdata` equal to `mem_rdata`.
- R5: A miss fills an invalid way before it evicts a valid one, and picks way 0 when both are invalid. After two misses to different tags of an empty set, both words hit.
- R6: Each set's use bit is set to the way not touched by the latest hit or fill in that set. A miss in a set whose two ways are both valid replaces the way the use bit names.
- R7: Every store raises `mem_req` with `mem_we`=1, `mem_addr` = address bits [31:2] and `mem_wdata` = the store data. It completes after `mem_ready`, and `cpu_hit` reports whether the address was cached.
- R8: A store hit overwrites the cached word and updates the set's use bit in the same way a read hit does.
- R9: A store miss allocates nothing: a later read of that address still misses.
- R10: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay constant from the cycle the request is raised until the cycle `mem_ready` is seen, however long the next level takes.
- R11: The sets are independent: two tags in each of the four sets can be resident at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, sampled only while cpu_busy is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_busy | output | 1 | A request is in flight |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access found its word in the cache (valid with cpu_done) |
| cpu_rdata | output | 32 | Load data (valid with cpu_done on a load) |
| mem_req | output | 1 | Next-level request, held until mem_ready |
| mem_we | output | 1 | Next-level request is a write |
| mem_addr | output | 30 | Next-level word address |
| mem_wdata | output | 32 | Next-level write data |
| mem_ready | input | 1 | One-cycle completion from the next level |
| mem_rdata | input | 32 | Next-level read data, valid with mem_ready |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, and four sets. With only four sets, the conflict, fill-order and eviction sequences are short. Any address below 0x100 reaches every set with several tags, and a 64-word model memory covers them all. The memory model's latency can be changed between scenarios, from zero wait cycles to several. This exercises the request hold path, and the same sequences are also run with an immediate answer.

// File: rtl/lru2_cache_pkg.sv
package lru2_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MEM  = 2'd2
  } cache_state_e;

  // Replacement choice: empty way first (way 0 before way 1), else the use bit.
  function automatic logic pick_victim(input logic [1:0] valid, input logic use_bit);
    if (!valid[0])      return 1'b0;
    else if (!valid[1]) return 1'b1;
    else                return use_bit;
  endfunction

endpackage

// File: rtl/lru2_way.sv
module lru2_way #(
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              hit,
  output logic              valid_o,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // Storage arrays carry no reset so they map onto plain RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign valid_o = valid_q[rd_idx];
  assign rd_data = data_mem[rd_idx];
  assign hit     = valid_o && (tag_mem[rd_idx] == rd_tag);

  // R5
  fill_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/lru2_use.sv
module lru2_use #(
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             lru_way,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way
);

  logic [SETS-1:0] use_q;

  always_ff @(posedge clk) begin
    if (rst) use_q <= '0;
    else if (touch_en) use_q[touch_idx] <= ~touch_way;
  end

  assign lru_way = use_q[rd_idx];

  // R6
  use_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !touch_en |=> $stable(use_q));

endmodule

// File: rtl/lru2_cache.sv
module lru2_cache
  import lru2_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  localparam int OFF_W   = 2,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_busy,
  output logic               cpu_done,
  output logic               cpu_hit,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  input  logic [DATA_W-1:0]  mem_rdata
);

  cache_state_e      st;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              req_we;
  logic [DATA_W-1:0] req_wdata;
  logic              vict_q;
  logic              hit_q;

  logic [1:0]        way_hit;
  logic [1:0]        way_valid;
  logic [1:0]        way_wr;
  logic [DATA_W-1:0] way_data [2];
  logic [DATA_W-1:0] wr_word;
  logic              any_hit;
  logic              hit_way;
  logic              lru_way;
  logic              victim;
  logic              fill;
  logic              look;
  logic              touch_en;
  logic              touch_way;

  assign look      = (st == ST_LOOK);
  assign any_hit   = |way_hit;
  assign hit_way   = way_hit[1];
  assign victim    = pick_victim(way_valid, lru_way);
  assign fill      = (st == ST_MEM) && mem_ready && !req_we;
  assign wr_word   = fill ? mem_rdata : req_wdata;
  assign touch_en  = (look && any_hit) || fill;
  assign touch_way = fill ? vict_q : hit_way;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_wr[w] = (look && req_we && way_hit[w]) || (fill && (vict_q == w[0]));

    lru2_way #(
      .TAG_W (TAG_W),
      .DATA_W(DATA_W),
      .SETS  (SETS)
    ) u_way (
      .clk    (clk),
      .rst    (rst),
      .rd_idx (req_idx),
      .rd_tag (req_tag),
      .hit    (way_hit[w]),
      .valid_o(way_valid[w]),
      .rd_data(way_data[w]),
      .wr_en  (way_wr[w]),
      .wr_idx (req_idx),
      .wr_tag (req_tag),
      .wr_data(wr_word)
    );
  end

  lru2_use #(.SETS(SETS)) u_use (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .lru_way  (lru_way),
    .touch_en (touch_en),
    .touch_idx(req_idx),
    .touch_way(touch_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      req_idx   <= '0;
      req_tag   <= '0;
      req_we    <= 1'b0;
      req_wdata <= '0;
      vict_q    <= 1'b0;
      hit_q     <= 1'b0;
      cpu_busy  <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_hit   <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cpu_req) begin
            req_idx   <= cpu_addr[OFF_W +: IDX_W];
            req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
            req_we    <= cpu_we;
            req_wdata <= cpu_wdata;
            cpu_busy  <= 1'b1;
            st        <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!req_we && any_hit) begin
            cpu_rdata <= hit_way ? way_data[1] : way_data[0];
            cpu_hit   <= 1'b1;
            cpu_done  <= 1'b1;
            cpu_busy  <= 1'b0;
            st        <= ST_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= req_we;
            mem_addr  <= {req_tag, req_idx};
            mem_wdata <= req_wdata;
            vict_q    <= victim;
            hit_q     <= any_hit;
            st        <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (mem_ready) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            cpu_done <= 1'b1;
            cpu_busy <= 1'b0;
            cpu_hit  <= req_we ? hit_q : 1'b0;
            if (!req_we) cpu_rdata <= mem_rdata;
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  way_hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  // R3
  done_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !mem_req);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  store_miss_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
    (look && req_we && !any_hit) |-> (way_wr == 2'b00));

endmodule

// File: tb/tb_lru2_cache.sv
`timescale 1ns/1ps
module tb_lru2_cache;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_busy, cpu_done, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [31:0] bm [64];
  int          lat = 0;
  int          wait_cnt = 0;
  int          ops = 0;
  int          glitches = 0;
  int          req_cycles = 0;
  logic [29:0] first_addr = '0;
  logic [29:0] last_addr = '0;
  logic        last_we = 1'b0;
  logic [31:0] last_wdata = '0;

  always #2 clk = ~clk;

  lru2_cache dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // Next-level memory model, acting on falling edges.
  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        first_addr = mem_addr;
        req_cycles = 0;
      end else if (mem_addr != first_addr) begin
        glitches++;
      end
      req_cycles++;
      if (wait_cnt == lat) begin
        mem_ready  = 1'b1;
        last_addr  = mem_addr;
        last_we    = mem_we;
        last_wdata = mem_wdata;
        if (mem_we) bm[mem_addr[5:0]] = mem_wdata;
        else        mem_rdata = bm[mem_addr[5:0]];
        ops++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cpu_req = 1'b0;
    for (int i = 0; i < 64; i++) bm[i] = 32'h5A00_0000 + i * 32'h0001_0111;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // One processor access; expected values come from the model memory.
  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic exp_hit, input string req);
    int          ops0;
    int          cyc;
    logic [31:0] exp_d;
    int          exp_ops;
    ops0 = ops;
    cyc  = 0;
    @(negedge clk);
    exp_d = bm[a[7:2]];
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 1;
    while (!cpu_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(cpu_done, req, "completion", {31'd0, cpu_done}, 32'd1);
    chk(cpu_hit == exp_hit, req, "hit flag", {31'd0, cpu_hit}, {31'd0, exp_hit});
    if (!we) chk(cpu_rdata == exp_d, req, "load data", cpu_rdata, exp_d);
    exp_ops = (we || !exp_hit) ? 1 : 0;
    chk((ops - ops0) == exp_ops, req, "memory operations", ops - ops0, exp_ops);
    if (exp_ops == 1) begin
      chk(last_addr == a[31:2], req, "memory word address", {2'b00, last_addr}, {2'b00, a[31:2]});
      chk(last_we == we, req, "memory write flag", {31'd0, last_we}, {31'd0, we});
      if (we) chk(last_wdata == wd, req, "memory write data", last_wdata, wd);
      chk(req_cycles == lat + 1, req, "request held cycles", req_cycles, lat + 1);
    end
    if (!we && exp_hit) chk(cyc == 2, req, "hit latency", cyc, 2);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!cpu_busy && !cpu_done && !cpu_hit, "R1", "cpu flags after reset",
        {29'd0, cpu_busy, cpu_done, cpu_hit}, 32'd0);
    chk(!mem_req, "R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk(cpu_rdata == 32'd0, "R1", "rdata after reset", cpu_rdata, 32'd0);
    access(1'b0, 32'h0000_0000, '0, 1'b0, "R1");
  endtask

  task automatic t_basic();
    do_reset();
    access(1'b0, 32'h0000_0008, '0, 1'b0, "R4");
    access(1'b0, 32'h0000_0008, '0, 1'b1, "R3");
    access(1'b0, 32'h0000_000B, '0, 1'b1, "R2");
    access(1'b0, 32'h0000_0018, '0, 1'b0, "R2");
    access(1'b0, 32'h0000_0028, '0, 1'b0, "R2");
  endtask

  task automatic t_fill_order();
    do_reset();
    access(1'b0, 32'h0000_000C, '0, 1'b0, "R5");
    access(1'b0, 32'h0000_001C, '0, 1'b0, "R5");
    access(1'b0, 32'h0000_000C, '0, 1'b1, "R5");
    access(1'b0, 32'h0000_001C, '0, 1'b1, "R5");
  endtask

  task automatic t_lru_plain();
    do_reset();
    access(1'b0, 32'h0000_0004, '0, 1'b0, "R6");
    access(1'b0, 32'h0000_0024, '0, 1'b0, "R6");
    access(1'b0, 32'h0000_0054, '0, 1'b0, "R6");
    access(1'b0, 32'h0000_0024, '0, 1'b1, "R6");
    access(1'b0, 32'h0000_0004, '0, 1'b0, "R6");
    access(1'b0, 32'h0000_0024, '0, 1'b1, "R6");
  endtask

  task automatic t_lru_touch();
    do_reset();
    access(1'b0, 32'h0000_0004, '0, 1'b0, "R6");
    access(1'b0, 32'h0000_0024, '0, 1'b0, "R6");
    access(1'b0, 32'h0000_0004, '0, 1'b1, "R6");
    access(1'b0, 32'h0000_0054, '0, 1'b0, "R6");
    access(1'b0, 32'h0000_0004, '0, 1'b1, "R6");
    access(1'b0, 32'h0000_0024, '0, 1'b0, "R6");
  endtask

  task automatic t_sets();
    do_reset();
    for (int i = 0; i < 8; i++) access(1'b0, 32'(i * 4), '0, 1'b0, "R11");
    for (int i = 0; i < 8; i++) access(1'b0, 32'(i * 4), '0, 1'b1, "R11");
  endtask

  task automatic t_store();
    do_reset();
    access(1'b0, 32'h0000_0010, '0, 1'b0, "R7");
    access(1'b1, 32'h0000_0010, 32'hDEAD_BEEF, 1'b1, "R7");
    access(1'b0, 32'h0000_0010, '0, 1'b1, "R8");
    chk(bm[4] == 32'hDEAD_BEEF, "R7", "memory updated by store", bm[4], 32'hDEAD_BEEF);
    access(1'b1, 32'h0000_0030, 32'h1234_5678, 1'b0, "R9");
    access(1'b0, 32'h0000_0030, '0, 1'b0, "R9");
    chk(cpu_rdata == 32'h1234_5678, "R9", "store-miss word from memory", cpu_rdata, 32'h1234_5678);
  endtask

  task automatic t_store_use();
    do_reset();
    access(1'b0, 32'h0000_0000, '0, 1'b0, "R8");
    access(1'b0, 32'h0000_0020, '0, 1'b0, "R8");
    access(1'b1, 32'h0000_0000, 32'h0BAD_F00D, 1'b1, "R8");
    access(1'b0, 32'h0000_0040, '0, 1'b0, "R8");
    access(1'b0, 32'h0000_0000, '0, 1'b1, "R8");
    access(1'b0, 32'h0000_0020, '0, 1'b0, "R8");
  endtask

  task automatic t_latency();
    lat = 5;
    do_reset();
    access(1'b0, 32'h0000_0014, '0, 1'b0, "R10");
    access(1'b1, 32'h0000_0014, 32'hCAFE_0001, 1'b1, "R10");
    access(1'b0, 32'h0000_0014, '0, 1'b1, "R10");
    chk(glitches == 0, "R10", "address changed while waiting", glitches, 0);
    lat = 0;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_fill_order();
    t_lru_plain();
    t_lru_touch();
    t_sets();
    t_store();
    t_store_use();
    t_latency();
    lat = 2;
    t_lru_touch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule